// File: doc/BRIEF.md
# Framed Register-Write Command Decoder

This block sits behind a host-facing byte receiver and turns a framed byte stream into writes on a small register-file port. It watches incoming bytes, one per cycle when the valid input is high, for a fixed five-byte opening sequence. Once that sequence is seen it collects 16-bit command words, high byte first, until a closing byte arrives at a word boundary. Each word carries a 4-bit register address, an 8-bit data value spread over two bit groups, and two guard bits that must be the complements of data bits 5 and 7.

A word whose guard bits are correct produces a one-cycle write strobe with its address and data. A word whose guard bits are wrong is discarded and sets a sticky error flag. That flag stays set until the next complete opening sequence. Writes leave the block in the order their words arrived, so a host can pack a whole configuration sequence into one frame.

Top module: `cmd_frame_decoder`

## Requirements
- R1: After a synchronous active-high reset, `wr_en` and `err` are low and the decoder is searching for an opening sequence.
- R2: The payload phase begins only after the bytes 0x40, 0x4C, 0x44, 0x53, 0x7E arrive in that order on cycles with `in_valid` high. Cycles with `in_valid` low are ignored, and no write can occur while searching.
- R3: A byte that breaks the opening-sequence match restarts the search. If that byte is 0x40, it is taken as the first byte of a new sequence.
- R4: A word is formed as {first byte, second byte}. The address is word bits 11:8. The data is {word bits 13:12, word bits 5:0}. `wr_en` is high for exactly one cycle: the cycle after the second byte is accepted.
- R5: A word is valid only when word bit 6 equals the inverse of word bit 5 and word bit 14 equals the inverse of word bit 13. An invalid word produces no write and sets `err`.
- R6: `err` stays high until a complete opening sequence is received. It is low in the cycle after the last byte of that sequence.
- R7: The byte 0x7E ends the frame only when no high byte is pending; as a second byte it is treated as word data. After a frame ends, payload bytes produce no writes until a new opening sequence.
- R8: A frame may carry any number of words, and their writes appear in arrival order.
- R9: A reset during a frame discards any pending high byte and returns the decoder to searching, so the bytes that follow produce no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is valid this cycle |
| in_byte | input | 8 | Received byte |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register address for the write |
| wr_data | output | 8 | Register data for the write |
| err | output | 1 | Sticky malformed-word flag |

## Verification
The byte 0x7E can be read in two ways within one cycle: it can close the frame, or it can complete a word as its low byte. Which reading applies depends only on whether a high byte is pending. The bench provokes the clash by sending a high byte followed by 0x7E. That word fails its guard check, so the bench expects no write and `err` set, and it confirms the frame is still open because the next good word is still written. A second test sends 0x7E at a word boundary and then a full word. There the bench expects no write, because the frame has closed.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int PRE_LEN = 5;

    localparam logic [BYTE_W-1:0] TERM_BYTE = 8'h7E;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_BODY = 1'b1
    } cfd_state_e;

    typedef struct packed {
        logic              ok;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfd_cmd_t;

    // Opening sequence byte at a given position.
    function automatic logic [BYTE_W-1:0] pre_byte(input int idx);
        case (idx)
            0:       return 8'h40;
            1:       return 8'h4C;
            2:       return 8'h44;
            3:       return 8'h53;
            default: return 8'h7E;
        endcase
    endfunction

endpackage

// File: rtl/cfd_pre_match.sv
module cfd_pre_match
    import cfd_pkg::*;
#(
    parameter int LEN = PRE_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              hit
);
    localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        hit   = 1'b0;
        if (en) begin
            if (byte_in == pre_byte(int'(idx_q))) begin
                if (idx_q == LAST_IDX) begin
                    hit   = 1'b1;
                    idx_d = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end else if (byte_in == pre_byte(0)) begin
                idx_d = IDX_W'(1);
            end else begin
                idx_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_d;
    end

    AST_PRE_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q) < LEN) else $error("match index out of range"); // R3

    AST_PRE_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(idx_q)) else $error("index moved without a byte"); // R2

endmodule

// File: rtl/cfd_word_unpack.sv
module cfd_word_unpack
    import cfd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cfd_cmd_t          cmd
);
    logic guard_lo_ok, guard_hi_ok;

    always_comb begin
        guard_lo_ok = (word[6]  == ~word[5]);
        guard_hi_ok = (word[14] == ~word[13]);
        cmd.ok      = guard_lo_ok && guard_hi_ok;
        cmd.addr    = word[11:8];
        cmd.data    = {word[13:12], word[5:0]};
    end

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
    import cfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              err
);
    typedef struct packed {
        cfd_state_e        state;
        logic              pend;
        logic [BYTE_W-1:0] hi;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              err;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state:   ST_HUNT,
        pend:    1'b0,
        hi:      '0,
        wr_en:   1'b0,
        wr_addr: '0,
        wr_data: '0,
        err:     1'b0
    };

    regs_t    r_d, r_q;
    logic     hunt_en;
    logic     pre_hit;
    logic     body_byte;
    cfd_cmd_t cmd;

    assign hunt_en   = in_valid && (r_q.state == ST_HUNT);
    assign body_byte = in_valid && (r_q.state == ST_BODY);

    cfd_pre_match #(.LEN(PRE_LEN)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (hunt_en),
        .byte_in (in_byte),
        .hit     (pre_hit)
    );

    cfd_word_unpack u_unpack (
        .word (({r_q.hi, in_byte})),
        .cmd  (cmd)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        if (hunt_en && pre_hit) begin
            r_d.state = ST_BODY;
            r_d.pend  = 1'b0;
            r_d.err   = 1'b0;
        end
        if (body_byte) begin
            if (!r_q.pend) begin
                if (in_byte == TERM_BYTE) begin
                    r_d.state = ST_HUNT;
                end else begin
                    r_d.hi   = in_byte;
                    r_d.pend = 1'b1;
                end
            end else begin
                r_d.pend = 1'b0;
                if (cmd.ok) begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = cmd.addr;
                    r_d.wr_data = cmd.data;
                end else begin
                    r_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= REGS_RST;
        else     r_q <= r_d;
    end

    assign wr_en   = r_q.wr_en;
    assign wr_addr = r_q.wr_addr;
    assign wr_data = r_q.wr_data;
    assign err     = r_q.err;

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en) else $error("write strobe longer than one cycle"); // R4

    AST_WR_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(body_byte && r_q.pend)) else $error("write without a low byte"); // R4

    AST_NO_WR_HUNT: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_HUNT) |=> !wr_en) else $error("write while searching"); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err && !(hunt_en && pre_hit)) |=> err) else $error("error flag dropped early"); // R6

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (hunt_en && pre_hit) |=> !err) else $error("error flag not cleared"); // R6

    AST_TERM_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (body_byte && r_q.pend) |=> (r_q.state == ST_BODY)) else $error("frame closed mid-word"); // R7

    AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        (body_byte && r_q.pend && !cmd.ok) |=> (err && !wr_en)) else $error("bad word not flagged"); // R5

endmodule

// File: tb/tb_cmd_frame_decoder.sv
module tb_cmd_frame_decoder;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] log_addr [0:31];
    logic [7:0] log_data [0:31];
    int         nlog = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_frame_decoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err(err)
    );

    always @(negedge clk) begin
        if (!rst && wr_en && nlog < 32) begin
            log_addr[nlog] = wr_addr;
            log_data[nlog] = wr_data;
            nlog++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkword(input logic [3:0] a, input logic [7:0] d);
        logic [15:0] w;
        w = '0;
        w[5:0]   = d[5:0];
        w[6]     = ~d[5];
        w[11:8]  = a;
        w[13:12] = d[7:6];
        w[14]    = ~d[7];
        return w;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_byte  = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_pre();
        send_byte(8'h40); send_byte(8'h4C); send_byte(8'h44);
        send_byte(8'h53); send_byte(8'h7E);
    endtask

    task automatic send_word(input logic [15:0] w);
        send_byte(w[15:8]);
        send_byte(w[7:0]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        nlog = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check(wr_en == 1'b0, "R1 wr_en", int'(wr_en), 0);
        check(err == 1'b0, "R1 err", int'(err), 0);
    endtask

    task automatic t_basic();
        do_reset();
        send_pre();
        send_word(mkword(4'h3, 8'hA5));
        check(wr_en == 1'b1, "R4 strobe after low byte", int'(wr_en), 1);
        check(wr_addr == 4'h3 && wr_data == 8'hA5, "R4 fields",
              int'({wr_addr, wr_data}), 'h3A5);
        idle(1);
        check(wr_en == 1'b0, "R4 strobe one cycle", int'(wr_en), 0);
        send_byte(8'h7E);
        idle(2);
        check(nlog == 1, "R4 write count", nlog, 1);
    endtask

    task automatic t_order();
        logic [3:0] ea [3];
        logic [7:0] ed [3];
        ea = '{4'h1, 4'hF, 4'h0};
        ed = '{8'h00, 8'hFF, 8'h3C};
        do_reset();
        send_pre();
        for (int i = 0; i < 3; i++) send_word(mkword(ea[i], ed[i]));
        send_byte(8'h7E);
        idle(2);
        check(nlog == 3, "R8 write count", nlog, 3);
        for (int i = 0; i < 3; i++)
            check(log_addr[i] == ea[i] && log_data[i] == ed[i], "R8 order",
                  int'({log_addr[i], log_data[i]}), int'({ea[i], ed[i]}));
    endtask

    task automatic t_gaps();
        logic [15:0] w;
        w = mkword(4'h9, 8'h42);
        do_reset();
        send_byte(8'h40); idle(3); send_byte(8'h4C); idle(1);
        send_byte(8'h44); send_byte(8'h53); idle(2); send_byte(8'h7E);
        send_byte(w[15:8]); idle(4);
        check(nlog == 0, "R2 no write while high pending", nlog, 0);
        send_byte(w[7:0]);
        idle(2);
        check(nlog == 1 && log_addr[0] == 4'h9 && log_data[0] == 8'h42,
              "R2 gapped frame", int'({log_addr[0], log_data[0]}), 'h942);
    endtask

    task automatic t_restart();
        do_reset();
        send_byte(8'h40); send_byte(8'h4C); send_byte(8'h00);
        send_byte(8'h44); send_byte(8'h53); send_byte(8'h7E);
        send_word(mkword(4'h2, 8'h11));
        idle(2);
        check(nlog == 0, "R3 broken sequence no write", nlog, 0);
        send_byte(8'h40); send_byte(8'h4C); send_byte(8'h40);
        send_byte(8'h4C); send_byte(8'h44); send_byte(8'h53); send_byte(8'h7E);
        send_word(mkword(4'h6, 8'h77));
        idle(2);
        check(nlog == 1 && log_addr[0] == 4'h6 && log_data[0] == 8'h77,
              "R3 restart on 0x40", int'({log_addr[0], log_data[0]}), 'h677);
    endtask

    task automatic t_bad_word();
        do_reset();
        send_pre();
        send_word(mkword(4'h1, 8'h21));
        send_word(mkword(4'h2, 8'h22) ^ 16'h0040);
        check(err == 1'b1, "R5 low guard error", int'(err), 1);
        send_word(mkword(4'h3, 8'h23) ^ 16'h4000);
        send_word(mkword(4'h4, 8'h24));
        send_byte(8'h7E);
        idle(2);
        check(nlog == 2, "R5 bad words dropped", nlog, 2);
        check(log_addr[1] == 4'h4, "R5 next good word", int'(log_addr[1]), 4);
        check(err == 1'b1, "R6 sticky after frame", int'(err), 1);
        send_byte(8'h40); send_byte(8'h4C);
        check(err == 1'b1, "R6 partial sequence keeps err", int'(err), 1);
        send_byte(8'h44); send_byte(8'h53); send_byte(8'h7E);
        check(err == 1'b0, "R6 cleared by sequence", int'(err), 0);
    endtask

    task automatic t_term();
        logic [15:0] w;
        w = mkword(4'h5, 8'h00);
        do_reset();
        send_pre();
        send_byte(w[15:8]);
        send_byte(8'h7E);
        check(err == 1'b1 && wr_en == 1'b0, "R7 0x7E as low byte", int'(err), 1);
        send_word(mkword(4'hA, 8'h99));
        idle(1);
        check(nlog == 1 && log_addr[0] == 4'hA, "R7 frame still open",
              int'(log_addr[0]), 'hA);
        send_byte(8'h7E);
        send_word(mkword(4'hB, 8'h55));
        idle(2);
        check(nlog == 1, "R7 closed frame ignores words", nlog, 1);
    endtask

    task automatic t_mid_reset();
        logic [15:0] w;
        w = mkword(4'hC, 8'h81);
        do_reset();
        send_pre();
        send_word(mkword(4'h1, 8'h01) ^ 16'h0040);
        send_byte(w[15:8]);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        check(err == 1'b0, "R9 reset clears err", int'(err), 0);
        send_byte(w[7:0]);
        send_word(mkword(4'hD, 8'h82));
        idle(2);
        check(nlog == 0, "R9 no write after reset", nlog, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_byte  = 8'h00;
        @(posedge clk);
        #1;
        t_reset();
        t_basic();
        t_order();
        t_gaps();
        t_restart();
        t_bad_word();
        t_term();
        t_mid_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule